// File: doc/BRIEF.md
# Asynchronous Serial Port with Address Filtering and Flow Control

This block is a full-duplex asynchronous serial transmitter and receiver. Words to send enter through a valid/ready stream and queue in an 8-entry transmit FIFO. Received words leave through a second valid/ready stream fed from an 8-entry receive FIFO. A local divider makes an oversampling tick, and each bit lasts 16 ticks. A frame is one low start bit, 5 to 8 data bits sent LSB first, an optional ninth bit, and one high stop bit.

The ninth bit can carry even parity or odd parity. It can also act as an address marker, so that several nodes can share one line and each one accepts only the traffic sent to its own address. Optional hardware flow control uses an active-low ready-to-send output and an active-low clear-to-send input. Frame, parity, overrun and clear-to-send change events are held in sticky flags. Two level flags and two DMA request lines follow the FIFO fill levels.

Back-pressure rules: a transmit word is taken on a cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low only while the transmit FIFO is full. `rx_valid` stays high and `rx_data` stays unchanged until `rx_ready` is sampled high. The line has no back-pressure, so a word that arrives while the receive FIFO is full is lost and flagged as an overrun.

Top module: `uart_md_fc`

## Requirements
- R1: After reset, `txd` is 1, `rts_n` is 0, `rx_valid` is 0, `tx_ready` is 1, `tx_dreq` is 1, `rx_dreq` is 0, and `irq_stat` is 0 when `cfg_rts_thr` is nonzero.
- R2: `cfg_wlen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, sent LSB first after a low start bit and followed by one high stop bit. Each bit lasts 16 ticks, and a tick occurs every `cfg_div`+1 clocks. Transmit data bits above the word length are ignored, received bits above it read as 0, and `txd` is high whenever no frame is being sent.
- R3: `cfg_mode` sets the ninth bit: 0 means there is no ninth bit, 1 means even parity (the ninth bit equals the XOR of the data bits), 2 means odd parity (its complement), and 3 means an address flag taken from `tx_data[8]`. `rx_data[8]` returns the received ninth bit, or 0 when there is none.
- R4: In the two parity modes, a received ninth bit that differs from the computed parity sets `irq_stat[1]`. The word is still delivered.
- R5: A stop bit sampled low sets `irq_stat[0]`, and the word is still delivered.
- R6: Each bit value is the majority of oversamples 7, 8 and 9. A start bit that is not low at its mid-bit sample is dropped as a glitch and produces no word.
- R7: In mode 3, a word with its ninth bit set is an address. An address that equals `cfg_md_addr` is stored and selects the node. Any other address deselects the node and is discarded. A word with its ninth bit clear is stored only while the node is selected. The node is deselected after reset.
- R8: A word that arrives while the receive FIFO is full, with no read in the same cycle, is dropped and sets `irq_stat[2]`. The words already stored are unchanged.
- R9: With `cfg_fc_en` set, no new frame starts while `cts_n` is high, but a frame already in progress completes. With `cfg_fc_en` clear, `cts_n` has no effect.
- R10: With `cfg_fc_en` set, `rts_n` is 1 while the receive FIFO holds at least `cfg_rts_thr` words, and 0 below that level. With `cfg_fc_en` clear, `rts_n` is 0.
- R11: `irq_stat[3]` is set by any change of the synchronized `cts_n`. Writing 1 to bit i of `irq_clr` clears sticky bit i (bits 0 to 3). A flag set and a clear in the same cycle leave the flag set. `irq` is the OR of `irq_stat & irq_en`.
- R12: `irq_stat[4]` is 1 while the receive level is at least `cfg_rts_thr`. `irq_stat[5]` is 1 while the transmit FIFO is full. `tx_dreq` is 1 while the transmit FIFO holds at most 4 words. `rx_dreq` is 1 while the receive FIFO is not empty.
- R13: Data moves through both streams under the back-pressure rules stated above. Words come out in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 16 | Tick divider; one tick every cfg_div+1 clocks |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_mode | input | 2 | Ninth-bit mode: none, even, odd, address |
| cfg_md_addr | input | 8 | Node address for mode 3 |
| cfg_fc_en | input | 1 | Hardware flow control enable |
| cfg_rts_thr | input | 4 | Receive level threshold |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit FIFO can take a word |
| tx_data | input | 9 | Transmit word; bit 8 is the address flag in mode 3 |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the word |
| rx_data | output | 9 | Received word with the ninth bit in bit 8 |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rts_n | output | 1 | Active-low ready-to-send |
| cts_n | input | 1 | Active-low clear-to-send |
| irq_clr | input | 4 | Clear strobes for the sticky flags |
| irq_en | input | 6 | Interrupt mask |
| irq_stat | output | 6 | Frame, parity, overrun, cts change, rx level, tx full |
| irq | output | 1 | Masked interrupt |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |

## Verification
A sticky flag can be raised by a line event and cleared by software in the same cycle, and the required result is that the new event survives. The bench provokes this with the clear-to-send change flag. It toggles `cts_n` and holds the matching `irq_clr` bit high for exactly the three edges that cover the synchronizer and the edge detector, so the setting edge falls inside the clear window. It then releases the clear and expects `irq_stat[3]` to read 1. Clearing the flag without a new event must read 0.

// File: rtl/uart_md_pkg.sv
package uart_md_pkg;
  localparam logic [1:0] B9_NONE = 2'd0;
  localparam logic [1:0] B9_EVEN = 2'd1;
  localparam logic [1:0] B9_ODD  = 2'd2;
  localparam logic [1:0] B9_ADDR = 2'd3;
  localparam int         OSR     = 16;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_B9, S_STOP} ser_state_e;

  function automatic logic [7:0] mask_word(input logic [7:0] d, input logic [1:0] wlen);
    return d & (8'hFF >> (2'd3 - wlen));
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] mode);
    return (mode == B9_ODD) ? ~(^d) : ^d;
  endfunction

  function automatic logic [2:0] last_idx(input logic [1:0] wlen);
    return 3'd4 + {1'b0, wlen};
  endfunction
endpackage

// File: rtl/uart_md_fifo.sv
module uart_md_fifo #(
  parameter int W = 9,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      if (do_push && !do_pop)      count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/uart_md_baud.sv
module uart_md_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_md_tx.sv
module uart_md_tx import uart_md_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] wlen,
  input  logic [1:0] mode,
  input  logic       start_ok,
  input  logic [8:0] word,
  output logic       pop,
  output logic       txd,
  output logic       busy
);
  ser_state_e state;
  logic [3:0] sub;
  logic [2:0] idx;
  logic [7:0] shreg;
  logic       b9;
  logic [7:0] wmask;

  assign wmask = mask_word(word[7:0], wlen);
  assign pop   = (state == S_IDLE) && start_ok;
  assign busy  = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      txd   <= 1'b1;
      sub   <= '0;
      idx   <= '0;
      shreg <= '0;
      b9    <= 1'b0;
    end else if (state == S_IDLE) begin
      if (start_ok) begin
        state <= S_START;
        txd   <= 1'b0;
        sub   <= '0;
        shreg <= wmask;
        b9    <= (mode == B9_ADDR) ? word[8] : par_bit(wmask, mode);
      end
    end else if (tick) begin
      sub <= sub + 4'd1;
      if (sub == 4'(OSR - 1)) begin
        case (state)
          S_START: begin
            state <= S_DATA;
            idx   <= '0;
            txd   <= shreg[0];
          end
          S_DATA: begin
            if (idx == last_idx(wlen)) begin
              if (mode != B9_NONE) begin
                state <= S_B9;
                txd   <= b9;
              end else begin
                state <= S_STOP;
                txd   <= 1'b1;
              end
            end else begin
              idx   <= idx + 3'd1;
              shreg <= shreg >> 1;
              txd   <= shreg[1];
            end
          end
          S_B9: begin
            state <= S_STOP;
            txd   <= 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_md_rx.sv
module uart_md_rx import uart_md_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd_s,
  input  logic [1:0] wlen,
  input  logic [1:0] mode,
  output logic       done,
  output logic [8:0] word,
  output logic       ferr,
  output logic       perr
);
  ser_state_e state;
  logic [3:0] sub;
  logic [2:0] idx;
  logic [1:0] samp;
  logic [7:0] shreg;
  logic       b9;
  logic       vote;

  assign vote = (samp[0] & samp[1]) | (samp[0] & rxd_s) | (samp[1] & rxd_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sub   <= '0;
      idx   <= '0;
      samp  <= '0;
      shreg <= '0;
      b9    <= 1'b0;
      done  <= 1'b0;
      word  <= '0;
      ferr  <= 1'b0;
      perr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (state == S_IDLE) begin
          if (!rxd_s) begin
            state <= S_START;
            sub   <= 4'd1;
            shreg <= '0;
            b9    <= 1'b0;
          end
        end else begin
          sub <= sub + 4'd1;
          if (sub == 4'd7) samp[0] <= rxd_s;
          if (sub == 4'd8) samp[1] <= rxd_s;
          if (sub == 4'd9) begin
            case (state)
              S_START: if (vote) state <= S_IDLE;
              S_DATA:  shreg[idx] <= vote;
              S_B9:    b9 <= vote;
              default: begin
                done  <= 1'b1;
                word  <= {b9, shreg};
                ferr  <= !vote;
                perr  <= (mode == B9_EVEN || mode == B9_ODD) && (b9 != par_bit(shreg, mode));
                state <= S_IDLE;
              end
            endcase
          end
          if (sub == 4'(OSR - 1)) begin
            case (state)
              S_START: begin
                state <= S_DATA;
                idx   <= '0;
              end
              S_DATA: begin
                if (idx == last_idx(wlen)) state <= (mode != B9_NONE) ? S_B9 : S_STOP;
                else                       idx   <= idx + 3'd1;
              end
              S_B9:    state <= S_STOP;
              default: state <= S_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_md_fc.sv
module uart_md_fc import uart_md_pkg::*; #(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_wlen,
  input  logic [1:0]       cfg_mode,
  input  logic [7:0]       cfg_md_addr,
  input  logic             cfg_fc_en,
  input  logic [CNT_W-1:0] cfg_rts_thr,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [8:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [8:0]       rx_data,
  output logic             txd,
  input  logic             rxd,
  output logic             rts_n,
  input  logic             cts_n,
  input  logic [3:0]       irq_clr,
  input  logic [5:0]       irq_en,
  output logic [5:0]       irq_stat,
  output logic             irq,
  output logic             tx_dreq,
  output logic             rx_dreq
);
  logic             tick;
  logic             rxd_q1, rxd_s, cts_q1, cts_s, cts_prev;
  logic             tx_full, tx_empty, tx_pop, tx_busy, cts_blk;
  logic [8:0]       tx_word;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             rx_full, rx_empty, rx_pop, rx_push;
  logic             rx_done, rx_ferr, rx_perr, keep, md_sel;
  logic [8:0]       rx_word;
  logic [3:0]       flag_q, flag_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q1   <= 1'b1;
      rxd_s    <= 1'b1;
      cts_q1   <= 1'b0;
      cts_s    <= 1'b0;
      cts_prev <= 1'b0;
    end else begin
      rxd_q1   <= rxd;
      rxd_s    <= rxd_q1;
      cts_q1   <= cts_n;
      cts_s    <= cts_q1;
      cts_prev <= cts_s;
    end
  end

  uart_md_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
  );

  assign tx_ready = !tx_full;
  assign cts_blk  = cfg_fc_en && cts_s;

  uart_md_fifo #(.W(9), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_valid && tx_ready), .wdata(tx_data),
    .pop(tx_pop), .rdata(tx_word), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  uart_md_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wlen(cfg_wlen), .mode(cfg_mode),
    .start_ok(!tx_empty && !cts_blk), .word(tx_word), .pop(tx_pop),
    .txd(txd), .busy(tx_busy)
  );

  uart_md_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_s(rxd_s), .wlen(cfg_wlen),
    .mode(cfg_mode), .done(rx_done), .word(rx_word), .ferr(rx_ferr), .perr(rx_perr)
  );

  always_comb begin
    if (cfg_mode != B9_ADDR) keep = 1'b1;
    else if (rx_word[8])     keep = (rx_word[7:0] == cfg_md_addr);
    else                     keep = md_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      md_sel <= 1'b0;
    else if (rx_done && cfg_mode == B9_ADDR && rx_word[8]) md_sel <= (rx_word[7:0] == cfg_md_addr);
  end

  assign rx_push  = rx_done && keep;
  assign rx_valid = !rx_empty;
  assign rx_pop   = rx_valid && rx_ready;

  uart_md_fifo #(.W(9), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_data), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign flag_set = {cts_s != cts_prev,
                     rx_push && rx_full && !rx_pop,
                     rx_push && rx_perr,
                     rx_push && rx_ferr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~irq_clr) | flag_set;
  end

  assign irq_stat = {tx_full, rx_cnt >= cfg_rts_thr, flag_q};
  assign irq      = |(irq_stat & irq_en);
  assign rts_n    = cfg_fc_en && (rx_cnt >= cfg_rts_thr);
  assign tx_dreq  = (tx_cnt <= CNT_W'(FIFO_DEPTH / 2));
  assign rx_dreq  = !rx_empty;
endmodule

// File: rtl/uart_md_fc_chk.sv
module uart_md_fc_chk #(
  parameter int FIFO_DEPTH = 8,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [8:0]       rx_data,
  input logic [5:0]       irq_stat,
  input logic [3:0]       irq_clr,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [CNT_W-1:0] cfg_rts_thr,
  input logic             cfg_fc_en,
  input logic             rts_n,
  input logic             tx_busy,
  input logic             cts_blk,
  input logic             txd
);
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R13

  AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat[0] && !irq_clr[0] |=> irq_stat[0]); // R5

  AST_RX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(FIFO_DEPTH)); // R8

  AST_CTS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy && cts_blk |=> !tx_busy); // R9

  AST_RTS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fc_en && (rx_cnt >= cfg_rts_thr) |-> rts_n); // R10

  AST_TXD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R2
endmodule

bind uart_md_fc uart_md_fc_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .irq_stat(irq_stat), .irq_clr(irq_clr), .rx_cnt(rx_cnt),
  .cfg_rts_thr(cfg_rts_thr), .cfg_fc_en(cfg_fc_en), .rts_n(rts_n),
  .tx_busy(tx_busy), .cts_blk(cts_blk), .txd(txd)
);

// File: tb/uart_md_fc_test.sv
module uart_md_fc_test;
  localparam int CLK_PERIOD = 10;
  localparam int BITCLK = 32; // 16 ticks x (cfg_div+1 = 2) clocks

  // {wlen[1:0], mode[1:0], tx word[8:0], expected rx word[8:0]}
  localparam logic [21:0] VEC [8] = '{
    {2'd0, 2'd0, 9'h0FF, 9'h01F},
    {2'd1, 2'd1, 9'h1A5, 9'h125},
    {2'd2, 2'd2, 9'h07E, 9'h17E},
    {2'd3, 2'd0, 9'h1C3, 9'h0C3},
    {2'd3, 2'd1, 9'h0F0, 9'h0F0},
    {2'd3, 2'd2, 9'h081, 9'h181},
    {2'd2, 2'd1, 9'h0D5, 9'h055},
    {2'd0, 2'd2, 9'h013, 9'h013}
  };

  logic clk = 0, rst_n = 0;
  logic [15:0] cfg_div = 16'd1;
  logic [1:0] cfg_wlen = 2'd3, cfg_mode = 2'd0;
  logic [7:0] cfg_md_addr = 8'h5A;
  logic cfg_fc_en = 0;
  logic [3:0] cfg_rts_thr = 4'd3;
  logic tx_valid = 0, rx_ready = 0, cts_n = 0, brx = 1, loop = 1;
  logic [8:0] tx_data = '0;
  logic [3:0] irq_clr = '0;
  logic [5:0] irq_en = '0;
  logic tx_ready, rx_valid, txd, rts_n, irq, tx_dreq, rx_dreq;
  logic [8:0] rx_data;
  logic [5:0] irq_stat;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_md_fc uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_wlen(cfg_wlen), .cfg_mode(cfg_mode),
    .cfg_md_addr(cfg_md_addr), .cfg_fc_en(cfg_fc_en), .cfg_rts_thr(cfg_rts_thr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .txd(txd), .rxd(loop ? txd : brx), .rts_n(rts_n), .cts_n(cts_n),
    .irq_clr(irq_clr), .irq_en(irq_en), .irq_stat(irq_stat), .irq(irq),
    .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx(input logic [8:0] d);
    @(negedge clk);
    tx_valid = 1; tx_data = d;
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic get_rx(output logic [8:0] d);
    d = '1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (rx_valid) begin
        d = rx_data;
        rx_ready = 1;
        @(negedge clk);
        rx_ready = 0;
        break;
      end
    end
  endtask

  task automatic clear_flags();
    @(negedge clk); irq_clr = 4'hF;
    @(negedge clk); irq_clr = 4'h0;
  endtask

  task automatic serial_send(input logic [8:0] d, input int nb, input bit with9, input bit stopv);
    @(negedge clk);
    brx = 0; wait_clk(BITCLK);
    for (int i = 0; i < nb; i++) begin brx = d[i]; wait_clk(BITCLK); end
    if (with9) begin brx = d[8]; wait_clk(BITCLK); end
    brx = stopv; wait_clk(BITCLK);
    brx = 1; wait_clk(BITCLK * 2);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] d;
    wait_clk(4);
    rst_n = 1;
    wait_clk(2);
    // R1 reset state
    chk("R1 txd", txd, 1); chk("R1 rts_n", rts_n, 0); chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 1); chk("R1 irq_stat", irq_stat, 0);
    chk("R1 dreq", {tx_dreq, rx_dreq}, 2'b10);

    // R2 R3 R13 loopback table
    foreach (VEC[i]) begin
      @(negedge clk);
      cfg_wlen = VEC[i][21:20]; cfg_mode = VEC[i][19:18];
      push_tx(VEC[i][17:9]);
      get_rx(d);
      chk($sformatf("R2/R3 vec%0d", i), d, VEC[i][8:0]);
    end

    // R5 frame error, word still delivered
    loop = 0; cfg_wlen = 2'd3; cfg_mode = 2'd0;
    clear_flags();
    serial_send(9'h03C, 8, 0, 0);
    get_rx(d);
    chk("R5 data", d, 9'h03C);
    chk("R5 flag", irq_stat[0], 1);
    wait_clk(400);
    chk("R5 no stray word", rx_valid, 0);

    // R4 parity error in even mode
    cfg_mode = 2'd1; clear_flags();
    serial_send(9'h103, 8, 1, 1);
    get_rx(d);
    chk("R4 data", d, 9'h103);
    chk("R4 flag", irq_stat[1:0], 2'b10);

    // R6 short start glitch rejected
    cfg_mode = 2'd0;
    @(negedge clk); brx = 0; wait_clk(6); brx = 1;
    wait_clk(600);
    chk("R6 glitch", rx_valid, 0);

    // R7 multidrop filter
    cfg_mode = 2'd3;
    serial_send(9'h077, 8, 1, 1);
    serial_send(9'h133, 8, 1, 1);
    serial_send(9'h15A, 8, 1, 1);
    serial_send(9'h011, 8, 1, 1);
    serial_send(9'h122, 8, 1, 1);
    serial_send(9'h044, 8, 1, 1);
    get_rx(d); chk("R7 address", d, 9'h15A);
    get_rx(d); chk("R7 data", d, 9'h011);
    wait_clk(2);
    chk("R7 rest discarded", rx_valid, 0);

    // R10 RTS threshold
    cfg_mode = 2'd0; cfg_fc_en = 1; cfg_rts_thr = 4'd3;
    serial_send(9'h001, 8, 0, 1);
    serial_send(9'h002, 8, 0, 1);
    chk("R10 below", rts_n, 0);
    serial_send(9'h003, 8, 0, 1);
    chk("R10 at thr", rts_n, 1);
    chk("R12 rx level", irq_stat[4], 1);
    get_rx(d);
    chk("R10 drop", rts_n, 0);
    get_rx(d); get_rx(d);
    chk("R13 order", d, 9'h003);

    // R8 overrun
    cfg_fc_en = 0; cfg_rts_thr = 4'd8; clear_flags();
    for (int i = 0; i < 9; i++) serial_send(9'h040 + 9'(i), 8, 0, 1);
    chk("R8 flag", irq_stat[2], 1);
    chk("R12 full level", {irq_stat[4], rx_dreq}, 2'b11);
    d = rx_data; wait_clk(5);
    chk("R13 hold", {rx_valid, rx_data}, {1'b1, d});
    for (int i = 0; i < 8; i++) begin
      get_rx(d);
      chk($sformatf("R8 kept%0d", i), d, 9'h040 + 9'(i));
    end
    wait_clk(2);
    chk("R8 ninth dropped", {rx_valid, rx_dreq}, 2'b00);

    // R9 CTS gating, R11 change flag
    loop = 1; cfg_fc_en = 1; cts_n = 1;
    wait_clk(10);
    chk("R11 cts change", irq_stat[3], 1);
    clear_flags();
    chk("R11 cleared", irq_stat[3], 0);
    push_tx(9'h0A5);
    wait_clk(200);
    chk("R9 blocked", txd, 1);
    cts_n = 0; wait_clk(20);
    chk("R9 started", txd, 0);
    cts_n = 1;
    get_rx(d);
    chk("R9 completes", d, 9'h0A5);

    // R11 set and clear in the same cycle: set wins
    clear_flags();
    irq_en = 6'b001000;
    @(negedge clk); cts_n = 0; irq_clr = 4'b1000;
    wait_clk(3); irq_clr = 4'b0000;
    wait_clk(1);
    chk("R11 set wins", irq_stat[3], 1);
    chk("R11 irq", irq, 1);
    clear_flags();
    chk("R11 clear only", {irq_stat[3], irq}, 2'b00);

    // R9 flow control off: cts ignored
    cfg_fc_en = 0; cts_n = 1;
    push_tx(9'h033);
    get_rx(d);
    chk("R9 fc off", d, 9'h033);

    // R12 transmit level and DMA request
    loop = 0; cfg_fc_en = 1;
    wait_clk(5);
    chk("R12 tx_dreq empty", tx_dreq, 1);
    for (int i = 0; i < 8; i++) push_tx(9'h010 + 9'(i));
    chk("R12 tx full", {tx_ready, irq_stat[5], tx_dreq}, 3'b010);
    chk("R9 held idle", txd, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule